// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes a single load request from a 32-lane warp, in which every lane has an enable bit and a byte address for a 4-byte word. It reduces the request to the fewest 128-byte aligned line fetches that together cover every enabled lane. It then emits those fetches one at a time on a valid/ready output stream. Each fetch carries the aligned line address, a mask of the lanes that the line serves, and a mask of the 32-byte sectors within the line that those lanes actually touch.

When the last fetch of a request has been accepted, the block raises a one-cycle completion strobe. The strobe carries three figures for the finished request: how many lines were fetched, how many bytes the lanes asked for, and how many sectors were touched. From these figures, transfer efficiency (useful bytes over fetched bytes) and sectors per request can be derived downstream. A fully contiguous, aligned warp yields one line. A warp whose lanes stand 128 bytes apart yields 32 lines.

Both stream ports follow the usual rules. The request port transfers a request on a clock edge where `req_valid` and `req_ready` are both high. The line port transfers a fetch on an edge where `line_valid` and `line_ready` are both high. While `line_ready` is low, the presented fetch is held unchanged. A new request is taken only once the previous request's final fetch is being handed off, and it may be taken on that very edge. The completion strobe is a plain status output with no back-pressure.

Top module: `warp_coalescer`

## Requirements
- R1: A fetch's line address is a lane's byte address with its low 7 bits cleared. Every distinct line address among the enabled lanes is issued exactly once per request.
- R2: Bit i of a fetch's lane mask is set exactly when lane i is enabled and its line address equals the fetch address. The masks of one request never overlap, and their union equals the enabled-lane set. Disabled lanes, whatever their address, appear in no mask.
- R3: Fetches leave in ascending order of the lowest enabled lane index that maps to each line, regardless of address order.
- R4: At most one fetch transfers per clock. While `line_valid` is high and `line_ready` is low, `line_valid` stays high and `line_addr`, `line_mask` and `line_sectors` hold their values.
- R5: `req_ready` is high whenever no fetch is pending. While fetches are pending, it is high only in the cycle in which the final fetch is being accepted, so that a new request can be taken on that edge.
- R6: `done_valid` pulses for one cycle, in the cycle right after the edge on which the final fetch transferred. `done_lines` then equals the number of fetches issued for that request.
- R7: `done_bytes` equals 4 times the number of enabled lanes in the request.
- R8: Sector k (k = address bits 6:5) of a line is marked in bit k of `line_sectors` when a served lane falls in it. `done_sectors` is the total of marked sectors over the request's fetches.
- R9: A request with no enabled lanes issues no fetch. It completes with `done_valid` in the cycle after its acceptance (one cycle later if it was accepted on another request's final edge), with all three counts zero.
- R10: After reset, `line_valid` and `done_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_active | input | 32 | Per-lane enable, bit i = lane i |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits 32i+31:32i |
| line_valid | output | 1 | Line fetch present |
| line_ready | input | 1 | Downstream takes the fetch this cycle |
| line_addr | output | 32 | 128-byte aligned line address |
| line_mask | output | 32 | Lanes served by this line |
| line_sectors | output | 4 | 32-byte sectors of the line used by served lanes |
| done_valid | output | 1 | One-cycle completion strobe |
| done_lines | output | 6 | Fetches issued for the finished request |
| done_sectors | output | 6 | Sectors touched by the finished request |
| done_bytes | output | 8 | Useful bytes requested by the finished request |

## Verification
A request is taken on the edge where it is offered with `req_ready` high. The first fetch of that request is then visible on the next sampling point after that edge, because the lane state is registered and the line selection is combinational. Each fetch is compared against a lane-by-lane reference at the falling edge, after `line_ready` has been set for that cycle, so the transfer being recorded is the one the next rising edge will perform. The completion strobe is required at exactly the falling edge after the final transfer (the first falling edge after acceptance for an empty request), and the bench compares the cycle index of the strobe with the cycle index of the last recorded transfer. The back-to-back case checks `req_ready` in the pending cycle, in the final-transfer cycle and in the overlapping cycle where the old completion and the new first fetch coexist.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int DEF_LANES        = 32;
  localparam int DEF_ADDR_W       = 32;
  localparam int DEF_LINE_BYTES   = 128;
  localparam int DEF_SECTOR_BYTES = 32;
  localparam int DEF_WORD_BYTES   = 4;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/coal_lane_store.sv
module coal_lane_store #(
  parameter int LANES  = coal_pkg::DEF_LANES,
  parameter int ADDR_W = coal_pkg::DEF_ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_en,
  input  logic [LANES-1:0]        load_active,
  input  logic [LANES*ADDR_W-1:0] load_addr,
  input  logic                    clear_en,
  input  logic [LANES-1:0]        clear_mask,
  output logic [LANES-1:0]        pending,
  output logic [LANES*ADDR_W-1:0] addr_q
);
  // Lanes still waiting for a line; load wins over clear when both fire.
  always_ff @(posedge clk) begin
    if (!rst_n)        pending <= '0;
    else if (load_en)  pending <= load_active;
    else if (clear_en) pending <= pending & ~clear_mask;
  end

  always_ff @(posedge clk) begin
    if (load_en) addr_q <= load_addr;
  end

  AST_CLEAR_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |-> ((clear_mask & ~pending) == '0)); // R2
endmodule

// File: rtl/coal_line_pick.sv
module coal_line_pick #(
  parameter int LANES        = coal_pkg::DEF_LANES,
  parameter int ADDR_W       = coal_pkg::DEF_ADDR_W,
  parameter int LINE_BYTES   = coal_pkg::DEF_LINE_BYTES,
  parameter int SECTOR_BYTES = coal_pkg::DEF_SECTOR_BYTES,
  localparam int LINE_OFF    = $clog2(LINE_BYTES),
  localparam int SECT_OFF    = $clog2(SECTOR_BYTES),
  localparam int SECTORS     = LINE_BYTES / SECTOR_BYTES,
  localparam int SECT_W      = (SECTORS > 1) ? $clog2(SECTORS) : 1,
  localparam int TAG_W       = ADDR_W - LINE_OFF,
  localparam int LANE_W      = $clog2(LANES),
  localparam int SCNT_W      = coal_pkg::cnt_width(SECTORS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*ADDR_W-1:0] addr_q,
  output logic                    any,
  output logic [ADDR_W-1:0]       line_addr,
  output logic [LANES-1:0]        match,
  output logic [SECTORS-1:0]      sect_mask,
  output logic [SCNT_W-1:0]       sect_cnt,
  output logic                    last
);
  logic [TAG_W-1:0]  tag_a  [LANES];
  logic [SECT_W-1:0] sect_a [LANES];
  logic [LANE_W-1:0] lead;
  logic [TAG_W-1:0]  lead_tag;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign tag_a[g] = addr_q[g*ADDR_W + LINE_OFF +: TAG_W];
    if (SECTORS > 1) begin : g_sect
      assign sect_a[g] = addr_q[g*ADDR_W + SECT_OFF +: SECT_W];
    end else begin : g_nosect
      assign sect_a[g] = '0;
    end
  end

  // Lowest pending lane leads the next fetch.
  always_comb begin
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) lead = LANE_W'(i);
    end
  end

  assign any      = |pending;
  assign lead_tag = tag_a[lead];
  assign line_addr = {lead_tag, {LINE_OFF{1'b0}}};

  for (genvar g = 0; g < LANES; g++) begin : g_match
    assign match[g] = pending[g] && (tag_a[g] == lead_tag);
  end

  always_comb begin
    sect_mask = '0;
    for (int i = 0; i < LANES; i++) begin
      if (match[i]) sect_mask[sect_a[i]] = 1'b1;
    end
  end

  always_comb begin
    sect_cnt = '0;
    for (int k = 0; k < SECTORS; k++) begin
      sect_cnt = sect_cnt + SCNT_W'(sect_mask[k]);
    end
  end

  assign last = any && (match == pending);

  AST_MASK_IN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((match & ~pending) == '0) && (match != '0)); // R2
  AST_LEAD_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> match[lead] && ((pending & ((LANES'(1) << lead) - LANES'(1))) == '0)); // R3
endmodule

// File: rtl/coal_stats.sv
module coal_stats #(
  parameter int LANES      = coal_pkg::DEF_LANES,
  parameter int WORD_BYTES = coal_pkg::DEF_WORD_BYTES,
  parameter int SECTORS    = 4,
  localparam int CNT_W     = coal_pkg::cnt_width(LANES),
  localparam int BYTE_W    = coal_pkg::cnt_width(LANES * WORD_BYTES),
  localparam int SCNT_W    = coal_pkg::cnt_width(SECTORS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [LANES-1:0]  accept_active,
  input  logic              line_hs,
  input  logic              line_last,
  input  logic [SCNT_W-1:0] line_sect_cnt,
  output logic              done_valid,
  output logic [CNT_W-1:0]  done_lines,
  output logic [CNT_W-1:0]  done_sectors,
  output logic [BYTE_W-1:0] done_bytes
);
  logic [CNT_W-1:0]  line_acc, sect_acc, act_cnt;
  logic [BYTE_W-1:0] byte_q;
  logic              zero_pend;
  logic              accept_zero, final_hs, emit_zero;

  always_comb begin
    act_cnt = '0;
    for (int i = 0; i < LANES; i++) act_cnt = act_cnt + CNT_W'(accept_active[i]);
  end

  assign accept_zero = accept && (accept_active == '0);
  assign final_hs    = line_hs && line_last;
  assign emit_zero   = !final_hs && (zero_pend || accept_zero);

  // Running totals of the request in flight.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_acc <= '0;
      sect_acc <= '0;
      byte_q   <= '0;
    end else if (accept) begin
      line_acc <= '0;
      sect_acc <= '0;
      byte_q   <= BYTE_W'(act_cnt) * BYTE_W'(WORD_BYTES);
    end else if (line_hs) begin
      line_acc <= line_acc + 1'b1;
      sect_acc <= sect_acc + CNT_W'(line_sect_cnt);
    end
  end

  // Completion strobe; an empty request accepted on a final edge waits one cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid   <= 1'b0;
      done_lines   <= '0;
      done_sectors <= '0;
      done_bytes   <= '0;
      zero_pend    <= 1'b0;
    end else begin
      done_valid <= final_hs || emit_zero;
      if (final_hs) begin
        done_lines   <= line_acc + 1'b1;
        done_sectors <= sect_acc + CNT_W'(line_sect_cnt);
        done_bytes   <= byte_q;
        zero_pend    <= accept_zero;
      end else if (emit_zero) begin
        done_lines   <= '0;
        done_sectors <= '0;
        done_bytes   <= '0;
        zero_pend    <= zero_pend && accept_zero;
      end
    end
  end

  AST_LINE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_lines <= CNT_W'(LANES))); // R6
  AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_sectors >= done_lines)
                && ({2'b00, done_sectors} <= ({2'b00, done_lines} * (CNT_W+2)'(SECTORS)))); // R8
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> ((done_bytes == '0) == (done_lines == '0))); // R9
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES        = coal_pkg::DEF_LANES,
  parameter int ADDR_W       = coal_pkg::DEF_ADDR_W,
  parameter int LINE_BYTES   = coal_pkg::DEF_LINE_BYTES,
  parameter int SECTOR_BYTES = coal_pkg::DEF_SECTOR_BYTES,
  parameter int WORD_BYTES   = coal_pkg::DEF_WORD_BYTES,
  localparam int SECTORS     = LINE_BYTES / SECTOR_BYTES,
  localparam int CNT_W       = coal_pkg::cnt_width(LANES),
  localparam int BYTE_W      = coal_pkg::cnt_width(LANES * WORD_BYTES),
  localparam int SCNT_W      = coal_pkg::cnt_width(SECTORS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_active,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic                    line_valid,
  input  logic                    line_ready,
  output logic [ADDR_W-1:0]       line_addr,
  output logic [LANES-1:0]        line_mask,
  output logic [SECTORS-1:0]      line_sectors,
  output logic                    done_valid,
  output logic [CNT_W-1:0]        done_lines,
  output logic [CNT_W-1:0]        done_sectors,
  output logic [BYTE_W-1:0]       done_bytes
);
  logic [LANES-1:0]        pending;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic                    any, last, accept, line_hs;
  logic [SCNT_W-1:0]       sect_cnt;

  assign line_hs   = line_valid && line_ready;
  assign req_ready = !any || (line_hs && last);
  assign accept    = req_valid && req_ready;

  coal_lane_store #(.LANES(LANES), .ADDR_W(ADDR_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .load_en(accept), .load_active(req_active), .load_addr(req_addr),
    .clear_en(line_hs), .clear_mask(line_mask),
    .pending(pending), .addr_q(addr_q)
  );

  coal_line_pick #(
    .LANES(LANES), .ADDR_W(ADDR_W),
    .LINE_BYTES(LINE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
  ) pick_i (
    .clk(clk), .rst_n(rst_n),
    .pending(pending), .addr_q(addr_q),
    .any(any), .line_addr(line_addr), .match(line_mask),
    .sect_mask(line_sectors), .sect_cnt(sect_cnt), .last(last)
  );

  assign line_valid = any;

  coal_stats #(.LANES(LANES), .WORD_BYTES(WORD_BYTES), .SECTORS(SECTORS)) stats_i (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .accept_active(req_active),
    .line_hs(line_hs), .line_last(last), .line_sect_cnt(sect_cnt),
    .done_valid(done_valid), .done_lines(done_lines),
    .done_sectors(done_sectors), .done_bytes(done_bytes)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && !line_ready |=> line_valid && $stable(line_addr)
                                && $stable(line_mask) && $stable(line_sectors)); // R4
  AST_NO_TAKE_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && !line_ready |-> !req_ready); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    line_hs && (line_mask == pending) |=> done_valid); // R6
endmodule

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb_top;
  localparam int LANES  = 32;
  localparam int ADDR_W = 32;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] stride;
    logic [31:0] active;
    logic [7:0]  lines;
    logic [7:0]  bytes;
    logic [7:0]  sects;
    logic        bp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1000, 32'd4,         32'hFFFF_FFFF, 8'd1,  8'd128, 8'd4,  1'b0},
    '{32'h0000_0000, 32'd128,       32'hFFFF_FFFF, 8'd32, 8'd128, 8'd32, 1'b0},
    '{32'h0000_4000, 32'd8,         32'hFFFF_FFFF, 8'd2,  8'd128, 8'd8,  1'b1},
    '{32'h0000_5010, 32'd0,         32'hFFFF_FFFF, 8'd1,  8'd128, 8'd1,  1'b0},
    '{32'h0000_1040, 32'd4,         32'hFFFF_FFFF, 8'd2,  8'd128, 8'd4,  1'b1},
    '{32'h0000_2000, 32'd4,         32'h0000_FFFF, 8'd1,  8'd64,  8'd2,  1'b0},
    '{32'h0000_0000, 32'd32,        32'hFFFF_FFFF, 8'd8,  8'd128, 8'd32, 1'b1},
    '{32'h0000_3000, 32'd4,         32'h0000_0000, 8'd0,  8'd0,   8'd0,  1'b0},
    '{32'h0000_8000, 32'd128,       32'h8000_0001, 8'd2,  8'd8,   8'd2,  1'b0},
    '{32'h0000_9F80, 32'hFFFF_FF80, 32'h0000_000F, 8'd4,  8'd16,  8'd4,  1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                    req_valid = 1'b0, req_ready;
  logic [LANES-1:0]        req_active = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic                    line_valid, line_ready = 1'b0;
  logic [ADDR_W-1:0]       line_addr;
  logic [LANES-1:0]        line_mask;
  logic [3:0]              line_sectors;
  logic                    done_valid;
  logic [5:0]              done_lines, done_sectors;
  logic [7:0]              done_bytes;

  warp_coalescer dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr),
    .line_valid(line_valid), .line_ready(line_ready),
    .line_addr(line_addr), .line_mask(line_mask), .line_sectors(line_sectors),
    .done_valid(done_valid), .done_lines(done_lines),
    .done_sectors(done_sectors), .done_bytes(done_bytes)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  task automatic set_req(input logic [31:0] base, input logic [31:0] stride,
                         input logic [31:0] act);
    req_active = act;
    for (int i = 0; i < LANES; i++) begin
      if (act[i]) req_addr[i*ADDR_W +: ADDR_W] = base + stride * i;
      else        req_addr[i*ADDR_W +: ADDR_W] = 32'hDEAD_0000 + 32'(i) * 32'd128;
    end
  endtask

  function automatic logic [31:0] lane_addr(input int i);
    return req_addr[i*ADDR_W +: ADDR_W];
  endfunction

  task automatic run_vec(input vec_t v, input int idx);
    logic [31:0] served = '0;
    logic [31:0] snap_addr = '0, snap_mask = '0, exp_mask, exp_addr, lead_line;
    logic [3:0]  snap_sect = '0;
    int nlines = 0, last_hs = -1, done_cyc = -1, lead;
    bit seq_ok = 1'b1, stab_ok = 1'b1, hold = 1'b0;
    logic [31:0] addrs [LANES];
    @(negedge clk);
    set_req(v.base, v.stride, v.active);
    for (int i = 0; i < LANES; i++) addrs[i] = lane_addr(i);
    req_valid = 1'b1; line_ready = 1'b0;
    #1 check(req_ready == 1'b1, "R5", $sformatf("vec%0d idle ready", idx), req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      line_ready = v.bp ? cyc[0] : 1'b1;
      #1;
      if (done_valid) begin done_cyc = cyc; break; end
      if (line_valid) begin
        if (hold && (line_addr != snap_addr || line_mask != snap_mask || line_sectors != snap_sect))
          stab_ok = 1'b0;
        lead = -1;
        for (int i = LANES - 1; i >= 0; i--) if (v.active[i] && !served[i]) lead = i;
        exp_mask = '0; exp_addr = '0;
        if (lead >= 0) begin
          lead_line = {addrs[lead][31:7], 7'b0};
          exp_addr = lead_line;
          for (int i = 0; i < LANES; i++)
            if (v.active[i] && !served[i] && {addrs[i][31:7], 7'b0} == lead_line) exp_mask[i] = 1'b1;
        end
        if (lead < 0 || line_addr != exp_addr || line_mask != exp_mask) begin
          if (seq_ok) check(1'b0, "R1/R3", $sformatf("vec%0d line %0d addr", idx, nlines),
                            line_addr, exp_addr);
          seq_ok = 1'b0;
        end
        hold = !line_ready;
        snap_addr = line_addr; snap_mask = line_mask; snap_sect = line_sectors;
        if (line_ready) begin
          served = served | line_mask;
          nlines++;
          last_hs = cyc;
        end
      end else hold = 1'b0;
      @(negedge clk);
    end
    line_ready = 1'b0;
    check(seq_ok, "R3", $sformatf("vec%0d order and addresses", idx), seq_ok, 1);
    check(stab_ok, "R4", $sformatf("vec%0d held under back-pressure", idx), stab_ok, 1);
    check(served == v.active, "R2", $sformatf("vec%0d lane coverage", idx), served, v.active);
    check(nlines == int'(v.lines) && done_lines == v.lines[5:0], "R1",
          $sformatf("vec%0d line count", idx), done_lines, v.lines);
    check(done_cyc == last_hs + 1, "R6", $sformatf("vec%0d done cycle", idx), done_cyc, last_hs + 1);
    check(done_bytes == v.bytes, "R7", $sformatf("vec%0d useful bytes", idx), done_bytes, v.bytes);
    check(done_sectors == v.sects[5:0], "R8", $sformatf("vec%0d sectors", idx), done_sectors, v.sects);
    if (v.active == '0)
      check(nlines == 0 && done_cyc == 0, "R9", "empty request", done_cyc, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(line_valid == 1'b0, "R10", "line_valid after reset", line_valid, 0);
    check(done_valid == 1'b0, "R10", "done_valid after reset", done_valid, 0);
    check(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);

    for (int k = 0; k < NVEC; k++) run_vec(VECS[k], k);

    // Back-to-back: second request taken on the first one's final edge.
    @(negedge clk);
    set_req(32'h0, 32'd128, 32'h3);
    req_valid = 1'b1; line_ready = 1'b1;
    @(negedge clk);
    set_req(32'h1000, 32'd4, 32'hFFFF_FFFF);
    #1;
    check(line_valid && line_addr == 32'h0 && !req_ready, "R5", "busy blocks request",
          req_ready, 0);
    @(negedge clk);
    #1;
    check(line_addr == 32'h80 && req_ready, "R5", "ready on final fetch", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(done_valid && done_lines == 6'd2, "R6", "overlap completion", done_lines, 2);
    check(line_valid && line_addr == 32'h1000 && line_mask == 32'hFFFF_FFFF, "R5",
          "next request first fetch", line_addr, 32'h1000);
    @(negedge clk);
    #1;
    check(done_valid && done_lines == 6'd1 && done_bytes == 8'd128, "R6",
          "second completion", done_lines, 1);
    line_ready = 1'b0;

    // Stall: fetch held with ready low for several cycles.
    @(negedge clk);
    set_req(32'h7000, 32'd128, 32'h0000_0006);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(line_valid && line_addr == 32'h7080 && line_mask == 32'h2 && line_sectors == 4'h1,
          "R4", "stalled fetch held", line_addr, 32'h7080);
    line_ready = 1'b1;
    repeat (3) @(negedge clk);
    line_ready = 1'b0;
    #1;
    check(!line_valid, "R4", "stall drained", line_valid, 0);

    finish_run();
  end
endmodule